// File: doc/BRIEF.md
# Configuration Frame Scrubber

This controller keeps a configuration memory consistent with a golden copy while user logic goes on running. A programmable period timer starts a scrub pass at fixed intervals. In each pass the controller visits the frames in ascending index order. It reads every word of a frame from both the protected memory and the golden store at the same address, and it notes any difference. A frame that differs is rewritten word by word from the golden store. It is then read back once more. If the second read still differs, the frame is counted as a persistent error and an interrupt pulse is raised. No global reset is ever issued, so the frames that are not touched keep working. Frames whose readback path is shared with user logic, such as embedded RAM columns, are marked in an exclusion bitmap. The controller steps past them and makes no access to them.

A functional-interrupt alarm overrides all of this. The current frame is dropped at once, memory traffic stops, and a full-reload request is raised. That request also tells the rest of the system that user functions are unavailable. It stays high until the system acknowledges the reload. Scrubbing then resumes from frame 0 on the next timer tick.

The state machine has these states: IDLE (wait for a tick), SEEK (look at the skip bit of the current frame), READ (issue paired reads), DRAIN (compare the last word and decide), REPAIR (golden read, with the memory write one cycle later), FLUSH (last write, then arm the verify read), and RELOAD (full-reload request).

The transitions are:
- IDLE to SEEK on a tick.
- SEEK to SEEK on an excluded frame that is not the last frame.
- SEEK to IDLE on an excluded last frame.
- SEEK to READ otherwise.
- READ to DRAIN after the last word.
- DRAIN to REPAIR on a mismatch in the check phase.
- DRAIN to SEEK, or to IDLE after the last frame, otherwise.
- REPAIR to FLUSH after the last word.
- FLUSH to READ, which starts the verify phase.
- Any state to RELOAD on the alarm.
- RELOAD to IDLE on acknowledge.

Top module: `cfg_scrubber`

## Requirements
- R1: While reset is held and right after it is released, there are no memory or golden requests, `reload_req` and `pass_busy` are low, and both counters read 0.
- R2: A pass starts every max(`period_cycles`,1) cycles, counted from reset. `pass_busy` is high from the cycle after the tick until the pass ends. A tick that arrives during a pass or a reload is dropped.
- R3: Each visited frame f is read word by word in ascending word order, at address f*FRAME_WORDS+w. A memory read is always paired with a golden read at the same address in the same cycle. Read data is taken one cycle after the request.
- R4: A frame f with `skip_map[f]`=1 receives no read and no write, and its contents are left as they were.
- R5: A frame with any differing word is rewritten in full from the golden store. Each memory write goes to the address that the golden store read in the previous cycle. `fix_count` increases by 1 per rewritten frame. A frame with no difference is not written.
- R6: After a rewrite the frame is read again. If it still differs, `persist_count` increases by 1 and `persist_irq` is high for exactly one cycle. The frame is not rewritten a second time in that pass.
- R7: From the cycle after `sefi_alarm` is sampled high, `reload_req` is high, `pass_busy` is low, and no memory or golden request is issued. The frame in progress is abandoned.
- R8: `reload_req` stays high until `reload_ack` is sampled, and it is low in the following cycle. The next pass starts at frame 0.
- R9: Both counters saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_cycles | input | PER_W | Scrub interval in cycles |
| skip_map | input | N_FRAMES | Bit f excludes frame f |
| sefi_alarm | input | 1 | Functional-interrupt alarm |
| reload_ack | input | 1 | Full reload completed |
| mem_req | output | 1 | Protected memory access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Protected memory word address |
| mem_wdata | output | DATA_W | Write data (golden word) |
| mem_rdata | input | DATA_W | Read data, one cycle after request |
| gold_req | output | 1 | Golden store read |
| gold_addr | output | ADDR_W | Golden store word address |
| gold_rdata | input | DATA_W | Golden data, one cycle after request |
| reload_req | output | 1 | Full reload needed; user functions unavailable |
| pass_busy | output | 1 | A scrub pass is in progress |
| persist_irq | output | 1 | One-cycle pulse on a persistent error |
| fix_count | output | CNT_W | Frames rewritten (saturating) |
| persist_count | output | CNT_W | Persistent errors (saturating) |

## Verification
The assertions assume three things about the inputs. First, `skip_map` changes only while no pass is running, so an excluded frame never sees an access. Second, both stores return their data exactly one cycle after a request. Third, `reload_ack` comes only during a reload. The stimulus follows all three: the bench edits the bitmap, corrupts words and sets stuck bits only after `pass_busy` has fallen. It models both stores as one-cycle synchronous RAMs, and it acknowledges only while `reload_req` is high. Stuck bits are modelled as an XOR mask on the read path, so a rewrite cannot clear them.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SEEK,
        S_READ,
        S_DRAIN,
        S_REPAIR,
        S_FLUSH,
        S_RELOAD
    } scrub_state_e;
endpackage

// File: rtl/scrub_period_timer.sv
module scrub_period_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt_q;

    always_comb begin
        tick = (({1'b0, cnt_q} + (PER_W+1)'(1)) >= {1'b0, period});
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + PER_W'(1);
    end
endmodule

// File: rtl/scrub_frame_compare.sv
module scrub_frame_compare #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic              clear,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] gold_rdata,
    output logic              frame_bad
);
    logic             cmp_vld_q;
    logic             dirty_q;
    logic [LANES-1:0] lane_diff;
    logic             mis_now;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_diff[l] =
            (mem_rdata[l*LANE_W +: LANE_W] != gold_rdata[l*LANE_W +: LANE_W]);
    end

    always_comb begin
        mis_now   = cmp_vld_q && (|lane_diff);
        frame_bad = dirty_q || mis_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_vld_q <= 1'b0;
            dirty_q   <= 1'b0;
        end else begin
            cmp_vld_q <= rd_issue;
            if (clear) dirty_q <= 1'b0;
            else       dirty_q <= frame_bad;
        end
    end

    AST_DIRTY_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_vld_q && !clear |=> dirty_q == $past(dirty_q)); // R5
endmodule

// File: rtl/scrub_event_counter.sv
module scrub_event_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (evt && (count != '1))   count <= count + W'(1);
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        evt && (count != '1) |=> count == $past(count) + W'(1)); // R9
    AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '1) |=> count == '1); // R9
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(count)); // R9
endmodule

// File: rtl/cfg_scrubber.sv
module cfg_scrubber
    import scrub_pkg::*;
#(
    parameter int N_FRAMES    = 8,
    parameter int FRAME_WORDS = 4,
    parameter int DATA_W      = 16,
    parameter int PER_W       = 16,
    parameter int CNT_W       = 8,
    localparam int FRM_W      = $clog2(N_FRAMES),
    localparam int WRD_W      = $clog2(FRAME_WORDS),
    localparam int ADDR_W     = FRM_W + WRD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period_cycles,
    input  logic [N_FRAMES-1:0] skip_map,
    input  logic              sefi_alarm,
    input  logic              reload_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              gold_req,
    output logic [ADDR_W-1:0] gold_addr,
    input  logic [DATA_W-1:0] gold_rdata,
    output logic              reload_req,
    output logic              pass_busy,
    output logic              persist_irq,
    output logic [CNT_W-1:0]  fix_count,
    output logic [CNT_W-1:0]  persist_count
);
    scrub_state_e      state_q, state_d;
    logic [FRM_W-1:0]  frame_q;
    logic [WRD_W-1:0]  word_q;
    logic              verify_q;
    logic              wr_pend_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic              tick;
    logic              frame_bad;
    logic              frame_last;
    logic              word_last;
    logic              cur_skip;
    logic              fix_evt;
    logic              persist_evt;
    logic              cmp_clear;
    logic              rd_issue;

    scrub_period_timer #(.PER_W(PER_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .period(period_cycles), .tick(tick)
    );

    always_comb begin
        frame_last = (frame_q == FRM_W'(N_FRAMES - 1));
        word_last  = (word_q == WRD_W'(FRAME_WORDS - 1));
        cur_skip   = skip_map[frame_q];
        rd_issue   = (state_q == S_READ) && !sefi_alarm;
        cmp_clear  = (state_q != S_READ) && (state_q != S_DRAIN);
    end

    scrub_frame_compare #(.DATA_W(DATA_W)) cmp_i (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .clear(cmp_clear),
        .mem_rdata(mem_rdata), .gold_rdata(gold_rdata), .frame_bad(frame_bad)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (sefi_alarm && (state_q != S_RELOAD)) begin
            state_d = S_RELOAD;
        end else begin
            unique case (state_q)
                S_IDLE:   if (tick) state_d = S_SEEK;
                S_SEEK:   if (cur_skip) state_d = frame_last ? S_IDLE : S_SEEK;
                          else          state_d = S_READ;
                S_READ:   if (word_last) state_d = S_DRAIN;
                S_DRAIN:  if (frame_bad && !verify_q) state_d = S_REPAIR;
                          else state_d = frame_last ? S_IDLE : S_SEEK;
                S_REPAIR: if (word_last) state_d = S_FLUSH;
                S_FLUSH:  state_d = S_READ;
                S_RELOAD: if (reload_ack) state_d = S_IDLE;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Frame, word and phase tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= '0;
            word_q    <= '0;
            verify_q  <= 1'b0;
            wr_pend_q <= 1'b0;
            wr_addr_q <= '0;
        end else begin
            wr_pend_q <= (state_q == S_REPAIR) && !sefi_alarm;
            wr_addr_q <= {frame_q, word_q};
            unique case (state_q)
                S_IDLE, S_RELOAD: begin
                    frame_q  <= '0;
                    word_q   <= '0;
                    verify_q <= 1'b0;
                end
                S_SEEK: begin
                    word_q   <= '0;
                    verify_q <= 1'b0;
                    if (cur_skip) frame_q <= frame_q + FRM_W'(1);
                end
                S_READ, S_REPAIR: word_q <= word_q + WRD_W'(1);
                S_DRAIN: begin
                    word_q <= '0;
                    if (!(frame_bad && !verify_q)) begin
                        frame_q  <= frame_q + FRM_W'(1);
                        verify_q <= 1'b0;
                    end
                end
                S_FLUSH: begin
                    word_q   <= '0;
                    verify_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        gold_req    = 1'b0;
        reload_req  = 1'b0;
        pass_busy   = 1'b0;
        fix_evt     = 1'b0;
        persist_evt = 1'b0;
        mem_addr    = {frame_q, word_q};
        gold_addr   = {frame_q, word_q};
        mem_wdata   = gold_rdata;
        unique case (state_q)
            S_IDLE:   ;
            S_RELOAD: reload_req = 1'b1;
            S_READ: begin
                pass_busy = 1'b1;
                mem_req   = 1'b1;
                gold_req  = 1'b1;
            end
            S_REPAIR: begin
                pass_busy = 1'b1;
                gold_req  = 1'b1;
            end
            S_DRAIN: begin
                pass_busy   = 1'b1;
                fix_evt     = frame_bad && !verify_q && !sefi_alarm;
                persist_evt = frame_bad && verify_q && !sefi_alarm;
            end
            default:  pass_busy = 1'b1;
        endcase
        if (wr_pend_q && (state_q != S_RELOAD)) begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = wr_addr_q;
        end
        persist_irq = persist_evt;
    end

    scrub_event_counter #(.W(CNT_W)) fix_cnt_i (
        .clk(clk), .rst_n(rst_n), .evt(fix_evt), .count(fix_count)
    );
    scrub_event_counter #(.W(CNT_W)) persist_cnt_i (
        .clk(clk), .rst_n(rst_n), .evt(persist_evt), .count(persist_count)
    );

    AST_SEFI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        sefi_alarm |=> reload_req && !pass_busy); // R7
    AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |-> !mem_req && !gold_req); // R7
    AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req && !reload_ack && !sefi_alarm |=> reload_req); // R8
    AST_SKIP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !skip_map[mem_addr[ADDR_W-1:WRD_W]]); // R4
    AST_WRITE_SOURCED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(gold_req) && ($past(gold_addr) == mem_addr)); // R5
    AST_READ_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> gold_req && (gold_addr == mem_addr)); // R3
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        persist_irq |=> !persist_irq); // R6
endmodule

// File: tb/cfg_scrubber_tb_top.sv
module cfg_scrubber_tb_top;
    localparam int NW = 32;

    typedef struct packed {
        logic [7:0] skip;
        logic [2:0] frm;
        logic [1:0] wrd;
        logic       corrupt;
        logic       stuck;
        logic [3:0] efix;
        logic [3:0] eper;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'h00, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{8'h00, 3'd2, 2'd1, 1'b1, 1'b0, 4'd1, 4'd0},
        '{8'h00, 3'd7, 2'd3, 1'b1, 1'b0, 4'd1, 4'd0},
        '{8'h04, 3'd2, 2'd1, 1'b1, 1'b0, 4'd0, 4'd0},
        '{8'h81, 3'd0, 2'd2, 1'b1, 1'b0, 4'd0, 4'd0},
        '{8'h00, 3'd5, 2'd0, 1'b0, 1'b1, 4'd1, 4'd1},
        '{8'h20, 3'd5, 2'd0, 1'b0, 1'b1, 4'd0, 4'd0},
        '{8'hFF, 3'd3, 2'd2, 1'b1, 1'b0, 4'd0, 4'd0},
        '{8'h00, 3'd0, 2'd0, 1'b1, 1'b0, 4'd1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period_cycles = 16'd200;
    logic [7:0]  skip_map = 8'h00;
    logic        sefi_alarm = 1'b0;
    logic        reload_ack = 1'b0;
    logic        mem_req, mem_we, gold_req;
    logic [4:0]  mem_addr, gold_addr;
    logic [15:0] mem_wdata, mem_rdata, gold_rdata;
    logic        reload_req, pass_busy, persist_irq;
    logic [2:0]  fix_count, persist_count;

    logic [15:0] mem_arr   [NW];
    logic [15:0] gold_arr  [NW];
    logic [15:0] stuck_arr [NW];

    int n_checks = 0;
    int n_errors = 0;
    int skip_hits = 0;
    int irq_seen = 0;
    bit done = 0;
    logic       prev_gold_req = 1'b0;
    logic [4:0] prev_gold_addr = '0;

    always #4 clk = ~clk;

    cfg_scrubber #(.CNT_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .period_cycles(period_cycles),
        .skip_map(skip_map), .sefi_alarm(sefi_alarm), .reload_ack(reload_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .gold_req(gold_req), .gold_addr(gold_addr), .gold_rdata(gold_rdata),
        .reload_req(reload_req), .pass_busy(pass_busy), .persist_irq(persist_irq),
        .fix_count(fix_count), .persist_count(persist_count)
    );

    // Synchronous RAM models, one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem_arr[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem_arr[mem_addr] ^ stuck_arr[mem_addr];
        end
        if (gold_req) gold_rdata <= gold_arr[gold_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Port monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if ((mem_req && skip_map[mem_addr[4:2]]) || (gold_req && skip_map[gold_addr[4:2]]))
                skip_hits++;
            if (persist_irq) irq_seen++;
            if (mem_req && !mem_we)
                chk(gold_req && gold_addr == mem_addr, "R3 paired read addr", int'(gold_addr), int'(mem_addr));
            if (mem_we)
                chk(prev_gold_req && prev_gold_addr == mem_addr, "R5 write source addr", int'(prev_gold_addr), int'(mem_addr));
            prev_gold_req  = gold_req;
            prev_gold_addr = gold_addr;
        end
    end

    task automatic wait_pass;
        do @(negedge clk); while (!pass_busy);
        do @(negedge clk); while (pass_busy);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int a, f0, p0;
        do @(negedge clk); while (pass_busy);
        a = int'(v.frm) * 4 + int'(v.wrd);
        skip_map = v.skip;
        if (v.corrupt) mem_arr[a] = gold_arr[a] ^ 16'h0F0F;
        if (v.stuck)   stuck_arr[a] = 16'h0100;
        f0 = int'(fix_count);
        p0 = int'(persist_count);
        skip_hits = 0;
        irq_seen = 0;
        wait_pass();
        chk(int'(fix_count) - f0 == int'(v.efix), $sformatf("R5 fix delta vec %0d", idx), int'(fix_count) - f0, int'(v.efix));
        chk(int'(persist_count) - p0 == int'(v.eper), $sformatf("R6 persist delta vec %0d", idx), int'(persist_count) - p0, int'(v.eper));
        chk(irq_seen == int'(v.eper), $sformatf("R6 irq pulses vec %0d", idx), irq_seen, int'(v.eper));
        chk(skip_hits == 0, $sformatf("R4 skipped access vec %0d", idx), skip_hits, 0);
        for (int i = 0; i < NW; i++) begin
            if (!v.skip[i/4])
                chk(mem_arr[i] == gold_arr[i], $sformatf("R5 content vec %0d word %0d", idx, i), int'(mem_arr[i]), int'(gold_arr[i]));
        end
        if (v.corrupt && v.skip[v.frm])
            chk(mem_arr[a] == (gold_arr[a] ^ 16'h0F0F), $sformatf("R4 skipped frame kept vec %0d", idx), int'(mem_arr[a]), int'(gold_arr[a] ^ 16'h0F0F));
        mem_arr[a] = gold_arr[a];
        stuck_arr[a] = 16'h0000;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            gold_arr[i]  = 16'hA000 + 16'(i * 37);
            mem_arr[i]   = 16'hA000 + 16'(i * 37);
            stuck_arr[i] = 16'h0000;
        end
        repeat (3) @(negedge clk);
        chk(!mem_req && !gold_req && !reload_req && !pass_busy, "R1 quiet in reset", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !gold_req && !reload_req && !pass_busy, "R1 quiet after reset", int'(pass_busy), 0);
        chk(fix_count == 0 && persist_count == 0, "R1 counters zero", int'(fix_count), 0);

        for (int k = 0; k < 9; k++) run_vec(VECS[k], k);

        // R2: interval between pass starts
        begin
            int n = 0;
            skip_map = 8'h00;
            do @(negedge clk); while (!pass_busy);
            do @(negedge clk); while (pass_busy);
            do begin @(negedge clk); n++; end while (!pass_busy);
            begin
                int m = 0;
                do begin @(negedge clk); m++; end while (pass_busy);
                do begin @(negedge clk); m++; end while (!pass_busy);
                chk(m == 200, "R2 pass interval", m, 200);
            end
        end

        // R7/R8: alarm mid-frame
        do @(negedge clk); while (!(mem_req && !mem_we));
        sefi_alarm = 1'b1;
        @(negedge clk);
        sefi_alarm = 1'b0;
        chk(reload_req && !pass_busy && !mem_req && !gold_req, "R7 alarm abort", int'(reload_req), 1);
        begin
            int bad = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (!reload_req || mem_req || gold_req) bad++;
            end
            chk(bad == 0, "R8 request held without ack", bad, 0);
        end
        reload_ack = 1'b1;
        @(negedge clk);
        reload_ack = 1'b0;
        chk(!reload_req, "R8 request cleared after ack", int'(reload_req), 0);
        do @(negedge clk); while (!(mem_req && !mem_we));
        chk(mem_addr == 5'd0, "R8 resume at frame 0", int'(mem_addr), 0);

        // R9: saturation with a stuck word
        do @(negedge clk); while (pass_busy);
        stuck_arr[6] = 16'h0040;
        for (int p = 0; p < 9; p++) wait_pass();
        chk(persist_count == 3'd7, "R9 persist saturates", int'(persist_count), 7);
        chk(fix_count == 3'd7, "R9 fix saturates", int'(fix_count), 7);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule